// File: doc/BRIEF.md
# Mask-Driven Bit-Compaction Hash Engine

This block turns 32-bit integer keys into short hash values by keeping only the key bits selected by a programmable selection mask. The kept bits are packed together in the low end of each result, in their original relative order. All bits above them are cleared. The mask lives in a state register that is loaded before a stream of keys starts. It may only change while no keys are in flight.

Keys arrive as beats on two 128-bit load streams. Each stream carries four keys per beat, so one beat feeds eight parallel compaction lanes that share the mask. A beat enters when `ld_valid` and `ld_ready` are both high. Its eight results leave together on two 128-bit store streams, a fixed six cycles later. The engine accepts one beat per cycle. When the store side holds `st_ready` low, the whole pipeline freezes, and no beat is lost or reordered.

Top module: `bitx_hash_engine`

## Requirements
- R1: The selection mask resets to all zeros. A write with `mask_wr_en` while no beat is in flight loads `mask_wr_data` at that clock edge. Beats accepted after that edge use the new mask.
- R2: For each lane, the key bits at mask positions set to 1 appear in result bits 0..n-1 in ascending order, where n is the number of set mask bits. The key bit at the lowest selected position lands in result bit 0.
- R3: Result bits at position n and above are zero. An all-zero mask yields an all-zero result.
- R4: An all-ones mask returns every key unchanged.
- R5: Key word i of `ld0_data` (bits 32i+31..32i, i = 0..3) produces word i of `st0_data`. Key word i of `ld1_data` produces word i of `st1_data`.
- R6: With `st_ready` held high, a beat accepted in cycle c is presented with `st_valid` high in cycle c+6.
- R7: Beats accepted in consecutive cycles leave in consecutive cycles, so throughput is one eight-key beat per cycle.
- R8: A mask write while any beat is in flight is ignored, and the mask keeps its value. In that case `mask_err` is high for exactly the next cycle.
- R9: While `st_valid` is high and `st_ready` is low, `ld_ready` is low and the store outputs hold steady. Every accepted beat leaves exactly once, in acceptance order.
- R10: After reset, `st_valid` and `mask_err` are low and `ld_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mask_wr_en | input | 1 | Request to load the selection mask |
| mask_wr_data | input | 32 | New selection mask |
| mask_err | output | 1 | One-cycle flag: a mask write was refused because beats were in flight |
| ld_valid | input | 1 | Both load streams carry a beat |
| ld_ready | output | 1 | Engine takes the beat at this edge |
| ld0_data | input | 128 | Keys for lanes 0..3 |
| ld1_data | input | 128 | Keys for lanes 4..7 |
| st_valid | output | 1 | Both store streams carry a result beat |
| st_ready | input | 1 | Store side takes the result beat |
| st0_data | output | 128 | Results of lanes 0..3 |
| st1_data | output | 128 | Results of lanes 4..7 |

## Verification
The compaction is swept with every single-bit mask, which shows that each key position lands in result bit 0 when it is the only one selected. Empty and full masks pin down the clearing and pass-through extremes. Random masks with random keys, checked against a model that walks mask bits upward, separate correct ordering from reversed or offset packing. Distinct keys per lane expose crossed lane or port wiring. Back-to-back bursts, a refused mid-stream mask write and random store back-pressure show the timing, the refusal and order preservation.

// File: rtl/bitx_pkg.sv
package bitx_pkg;
  localparam int unsigned BITX_KEY_W = 32;
  typedef logic [BITX_KEY_W-1:0] key_t;

  // Clear unselected bits, then for each unselected position from the
  // second-highest downward, pull every higher bit down by one place.
  function automatic key_t bitx_compress(key_t key, key_t mask);
    key_t h;
    key_t hi_m;
    h = key & mask;
    for (int j = BITX_KEY_W - 2; j >= 0; j--) begin
      if (!mask[j]) begin
        hi_m = {BITX_KEY_W{1'b1}} << j;
        h = ((h & hi_m) >> 1) | (h & ~hi_m);
      end
    end
    return h;
  endfunction
endpackage

// File: rtl/bitx_mask_reg.sv
module bitx_mask_reg
  import bitx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  key_t wr_data,
  input  logic empty_i,
  output key_t mask_o,
  output logic err_o
);
  key_t mask_q;
  logic err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= wr_en & ~empty_i;
      if (wr_en && empty_i) mask_q <= wr_data;
    end
  end

  assign mask_o = mask_q;
  assign err_o  = err_q;

  // R8
  mask_busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !empty_i |=> $stable(mask_q));
  // R8
  mask_err_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !empty_i) |=> err_o);
  // R1
  mask_take_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && empty_i) |=> (mask_o == $past(wr_data)) && !err_o);
endmodule

// File: rtl/bitx_lane.sv
module bitx_lane
  import bitx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  key_t key_i,
  input  key_t mask_i,
  input  logic res_vld_i,
  output key_t res_o
);
  key_t and_q;
  key_t res_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      and_q <= '0;
      res_q <= '0;
    end else if (en) begin
      and_q <= key_i & mask_i;
      res_q <= bitx_compress(and_q, mask_i);
    end
  end

  assign res_o = res_q;

  // R3
  res_high_zero_chk: assert property (@(posedge clk) disable iff (rst)
    res_vld_i |-> ((res_q >> $countones(mask_i)) == '0));
endmodule

// File: rtl/bitx_stage.sv
module bitx_stage #(
  parameter int unsigned WIDTH = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             vld_i,
  input  logic [WIDTH-1:0] d_i,
  output logic             vld_o,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      q_o   <= '0;
    end else if (en) begin
      vld_o <= vld_i;
      q_o   <= d_i;
    end
  end
endmodule

// File: rtl/bitx_hash_engine.sv
module bitx_hash_engine
  import bitx_pkg::*;
#(
  parameter int unsigned PORT_W  = 128,
  parameter int unsigned LATENCY = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mask_wr_en,
  input  logic [31:0]       mask_wr_data,
  output logic              mask_err,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [PORT_W-1:0] ld0_data,
  input  logic [PORT_W-1:0] ld1_data,
  output logic              st_valid,
  input  logic              st_ready,
  output logic [PORT_W-1:0] st0_data,
  output logic [PORT_W-1:0] st1_data
);
  localparam int unsigned KW     = BITX_KEY_W;
  localparam int unsigned LANES  = 2 * (PORT_W / KW);
  localparam int unsigned DATA_W = LANES * KW;
  localparam int unsigned TAIL   = LATENCY - 3;

  logic              adv;
  logic              empty;
  logic [2:0]        mid_vld;
  logic [DATA_W-1:0] cap_q;
  logic [DATA_W-1:0] lane_res;
  logic [TAIL:0]     tvld;
  logic [DATA_W-1:0] tdat [0:TAIL];
  key_t              mask;

  assign adv      = ~(st_valid & ~st_ready);
  assign ld_ready = adv;
  assign empty    = ~(|mid_vld) & ~(|tvld);

  bitx_mask_reg u_mask (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (mask_wr_en),
    .wr_data(mask_wr_data),
    .empty_i(empty),
    .mask_o (mask),
    .err_o  (mask_err)
  );

  // Capture stage: both load streams, port 1 above port 0.
  always_ff @(posedge clk) begin
    if (rst) begin
      mid_vld <= '0;
      cap_q   <= '0;
    end else if (adv) begin
      mid_vld <= {mid_vld[1:0], ld_valid};
      cap_q   <= {ld1_data, ld0_data};
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bitx_lane u_lane (
      .clk      (clk),
      .rst      (rst),
      .en       (adv),
      .key_i    (cap_q[g*KW +: KW]),
      .mask_i   (mask),
      .res_vld_i(mid_vld[2]),
      .res_o    (lane_res[g*KW +: KW])
    );
  end

  assign tvld[0] = mid_vld[2];
  assign tdat[0] = lane_res;

  for (genvar s = 0; s < TAIL; s++) begin : g_tail
    bitx_stage #(.WIDTH(DATA_W)) u_stage (
      .clk  (clk),
      .rst  (rst),
      .en   (adv),
      .vld_i(tvld[s]),
      .d_i  (tdat[s]),
      .vld_o(tvld[s+1]),
      .q_o  (tdat[s+1])
    );
  end

  assign st_valid = tvld[TAIL];
  assign st0_data = tdat[TAIL][PORT_W-1:0];
  assign st1_data = tdat[TAIL][DATA_W-1:PORT_W];

  // R9
  st_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st_valid && !st_ready) |=> st_valid && $stable(st0_data) && $stable(st1_data));
  // R9
  no_take_in_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (st_valid && !st_ready) |-> !ld_ready);
endmodule

// File: tb/bitx_hash_engine_tb.sv
module bitx_hash_engine_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         mask_wr_en = 1'b0;
  logic [31:0]  mask_wr_data = '0;
  logic         mask_err;
  logic         ld_valid = 1'b0;
  logic         ld_ready;
  logic [127:0] ld0_data = '0;
  logic [127:0] ld1_data = '0;
  logic         st_valid;
  logic         st_ready = 1'b1;
  logic [127:0] st0_data;
  logic [127:0] st1_data;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic [31:0] exp_mask = '0;
  string cur_req = "R2";
  bit lat_mode = 0;
  bit rnd_ready = 0;
  bit first_out = 1;
  int last_out = 0;
  logic [255:0] exp_q [$];
  int acc_q [$];
  string req_q [$];

  always #2.5 clk = ~clk;

  bitx_hash_engine dut_i (
    .clk(clk), .rst(rst), .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
    .mask_err(mask_err), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld0_data(ld0_data), .ld1_data(ld1_data), .st_valid(st_valid),
    .st_ready(st_ready), .st0_data(st0_data), .st1_data(st1_data));

  function automatic logic [31:0] ref_pack(logic [31:0] k, logic [31:0] m);
    logic [31:0] r = '0;
    int n = 0;
    for (int b = 0; b < 32; b++) begin
      if (m[b]) begin
        r[n] = k[b];
        n++;
      end
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      finish_run();
    end
  end

  always @(posedge clk) begin
    #1;
    if (rnd_ready) st_ready = ($urandom % 3) != 0;
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (st_valid && st_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R9", {st1_data, st0_data}, '0);
        end else begin
          logic [255:0] e;
          int a;
          string rq;
          e = exp_q.pop_front();
          a = acc_q.pop_front();
          rq = req_q.pop_front();
          check({st1_data, st0_data} === e, rq, {st1_data, st0_data}, e);
          if (lat_mode) begin
            check(cyc - a == 6, "R6", cyc - a, 6);
            if (!first_out) check(cyc - last_out == 1, "R7", cyc - last_out, 1);
            first_out = 0;
            last_out = cyc;
          end
        end
      end
      if (st_valid && !st_ready) check(ld_ready == 1'b0, "R9", ld_ready, 0);
      if (ld_valid && ld_ready) begin
        logic [255:0] ins;
        logic [255:0] e;
        ins = {ld1_data, ld0_data};
        for (int i = 0; i < 8; i++) e[i*32 +: 32] = ref_pack(ins[i*32 +: 32], exp_mask);
        exp_q.push_back(e);
        acc_q.push_back(cyc);
        req_q.push_back(cur_req);
      end
    end
  end

  // mode 0: random keys, 1: distinct per-lane tags
  task automatic send_burst(int n, int mode);
    for (int b = 0; b < n; b++) begin
      for (int i = 0; i < 4; i++) begin
        ld0_data[i*32 +: 32] = (mode == 1) ? (32'hA5000000 | (b << 8) | i) : $urandom;
        ld1_data[i*32 +: 32] = (mode == 1) ? (32'h5A000000 | (b << 8) | (i + 4)) : $urandom;
      end
      ld_valid = 1'b1;
      @(negedge clk);
      while (!ld_ready) @(negedge clk);
      @(posedge clk);
      #1;
    end
    ld_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic write_mask_idle(logic [31:0] m);
    drain();
    @(posedge clk);
    #1;
    mask_wr_en = 1'b1;
    mask_wr_data = m;
    @(posedge clk);
    #1;
    mask_wr_en = 1'b0;
    exp_mask = m;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(st_valid == 1'b0, "R10", st_valid, 0);
    check(ld_ready == 1'b1, "R10", ld_ready, 1);
    check(mask_err == 1'b0, "R10", mask_err, 0);

    // R1 mask resets to zero; R3 zero mask clears results
    cur_req = "R1_R3";
    send_burst(2, 0);
    drain();

    // R4 all-ones mask passes keys through
    write_mask_idle(32'hFFFF_FFFF);
    check(mask_err == 1'b0, "R1", mask_err, 0);
    cur_req = "R4";
    send_burst(3, 0);

    // R5 lane and port mapping with distinct per-lane keys
    cur_req = "R5";
    send_burst(2, 1);

    // R2 every single-bit mask
    cur_req = "R2";
    for (int p = 0; p < 32; p++) begin
      write_mask_idle(32'h1 << p);
      send_burst(1, 0);
    end

    // R2 R3 random masks with random keys
    for (int t = 0; t < 40; t++) begin
      write_mask_idle($urandom);
      cur_req = "R2_R3";
      send_burst(3, (t % 5 == 0) ? 1 : 0);
    end
    write_mask_idle(32'h0);
    cur_req = "R3";
    send_burst(2, 0);

    // R6 R7 latency and back-to-back throughput
    write_mask_idle(32'h0F0F_3C3C);
    lat_mode = 1;
    first_out = 1;
    cur_req = "R6_R7";
    send_burst(10, 0);
    drain();
    lat_mode = 0;

    // R8 mask write while busy is refused
    write_mask_idle(32'h0000_FFFF);
    cur_req = "R8";
    send_burst(2, 0);
    mask_wr_en = 1'b1;
    mask_wr_data = 32'hFFFF_0000;
    @(posedge clk);
    #1;
    mask_wr_en = 1'b0;
    @(negedge clk);
    check(mask_err == 1'b1, "R8", mask_err, 1);
    @(negedge clk);
    check(mask_err == 1'b0, "R8", mask_err, 0);
    send_burst(2, 0);
    drain();

    // R9 random back-pressure
    write_mask_idle(32'hA5A5_1234);
    rnd_ready = 1;
    cur_req = "R9";
    send_burst(40, 0);
    drain();
    rnd_ready = 0;
    @(posedge clk);
    #1;
    st_ready = 1'b1;
    check(exp_q.size() == 0, "R9", exp_q.size(), 0);

    finish_run();
  end
endmodule